// File: doc/BRIEF.md
# Gamma Level Register Target on I2C

This block is an I2C target that stores a set of 10-bit reference levels for a gamma voltage divider, one 10-bit common-voltage level and four 16-bit control words. A controller first writes a pointer byte that selects a register, then transfers 16-bit words, upper byte first. After each complete word the pointer moves on by one, so a long burst can load all level registers in one transaction. Between the last level slot and the common-voltage slot lies a run of unused slots. Their data is acknowledged and thrown away, which lets one burst reach the common-voltage register.

Reads start with a write of the pointer byte. The controller then sends a repeated START and the device address with the read bit set, and the block returns words upper byte first. The pointer advances for each word for as long as the controller acknowledges. SCL and SDA are open-drain lines. The block samples both through synchronizers on the system clock and pulls SDA low only through an enable output. All stored values are also available on parallel outputs.

Top module: `gamma_i2c_target`

## Requirements
- R1: A byte after START whose upper seven bits equal the `DEV_ADDR` parameter is acknowledged, and bit 0 selects read (1) or write (0). Any other address is not acknowledged, and the block ignores the bus until the next START.
- R2: A pointer byte is acknowledged only when its bits 7:6 are 00 and its bits 5:0 are one of 0x00–0x07 (levels), 0x12 (common voltage) or 0x3C–0x3F (control). Any other pointer byte is not acknowledged and changes no register.
- R3: A written word arrives as bits 15:8 and then bits 7:0. Level and common-voltage registers keep bits 9:0 and read back with bits 15:10 at zero. Control registers keep all 16 bits.
- R4: A register changes only once both bytes of its word are received. A STOP or repeated START after only the upper byte leaves it unchanged.
- R5: In a write burst the pointer advances after each complete word. Slots 0x08–0x11 are acknowledged and discarded, so the 19th word of a burst that starts at 0x00 lands in the common-voltage register.
- R6: A control register (0x3C–0x3F) is written only by the first word after the pointer byte. Later words of the same burst that reach a control slot are acknowledged and discarded.
- R7: A written word whose bits 15:14 are 01 is acknowledged and leaves its target register unchanged, but the pointer still advances.
- R8: A read returns the register that the last pointer write selected, upper byte first. Addresses that hold no register read as 0x0000.
- R9: During a read the pointer advances by one word for each word the controller acknowledges. A not-acknowledge ends the read, and SDA stays released until the next START or STOP.
- R10: After reset all registers are zero and SDA is released. The SDA enable rises only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| dac_lvl_o | output | NUM_DAC*LVL_W | Level registers, slot 0 in the low bits |
| vcom_lvl_o | output | LVL_W | Common-voltage level |
| ctrl_o | output | 64 | Control words, 0x3C in the low 16 bits |

## Verification
The hardest case to reach from the ports is the common-voltage register loaded by the 19th word of one unbroken burst. That word has to cross ten discarded slots, and every one of them must be acknowledged. The bench produces it with bit-level bus tasks that drive 38 data bytes after a single pointer byte. It then checks that every level slot and the common-voltage output hold their own words. Partial words are also hard to reach, so the bench cuts transactions between the two bytes of a word with a STOP and with a repeated START.

// File: rtl/gt_pkg.sv
package gt_pkg;
    localparam int WORD_W = 16;
    localparam int PTR_W  = 6;
    localparam int CTRL_N = 4;

    localparam logic [PTR_W-1:0] VCOM_ADDR = 6'h12;
    localparam logic [PTR_W-1:0] CTRL_BASE = 6'h3C;
    localparam logic [1:0]       RSVD_TAG  = 2'b01;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_RX,
        LS_RX_ACK,
        LS_TX,
        LS_TX_ACK,
        LS_WAIT
    } link_st_e;

    typedef enum logic [1:0] {
        BK_DEV,
        BK_PTR,
        BK_HI,
        BK_LO
    } byte_kind_e;

    typedef struct packed {
        link_st_e        st;
        byte_kind_e      kind;
        logic [3:0]      bitn;
        logic [7:0]      sh;
        logic [7:0]      hold;
        logic            oe;
        logic            ack;
        logic            rd;
        logic            first;
        logic            half;
        logic [PTR_W-1:0] ptr;
    } link_s;
endpackage

// File: rtl/gt_sync.sv
module gt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic [STAGES:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-1:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[STAGES-1];
        assign prev_o[g] = chain_q[STAGES];
    end
endmodule

// File: rtl/gt_link.sv
module gt_link
    import gt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              scl_p,
    input  logic              sda_s,
    input  logic              sda_p,
    output logic [PTR_W-1:0]  probe_addr_o,
    input  logic              probe_ok_i,
    output logic [PTR_W-1:0]  rd_addr_o,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              cmt_en_o,
    output logic [PTR_W-1:0]  cmt_addr_o,
    output logic [WORD_W-1:0] cmt_data_o,
    output logic              cmt_first_o,
    output logic              sda_oe_o
);
    link_s d, q;
    logic  cmt_en;

    logic rise_w, fall_w, start_w, stop_w;
    assign rise_w  =  scl_s & ~scl_p;
    assign fall_w  = ~scl_s &  scl_p;
    assign start_w =  scl_s &  scl_p &  sda_p & ~sda_s;
    assign stop_w  =  scl_s &  scl_p & ~sda_p &  sda_s;

    always_comb begin
        d      = q;
        cmt_en = 1'b0;
        if (stop_w) begin
            d.st = LS_IDLE;
            d.oe = 1'b0;
        end else if (start_w) begin
            d.st   = LS_RX;
            d.kind = BK_DEV;
            d.bitn = 4'd0;
            d.oe   = 1'b0;
        end else begin
            case (q.st)
                LS_RX: begin
                    if (rise_w && q.bitn != 4'd8) begin
                        d.sh   = {q.sh[6:0], sda_s};
                        d.bitn = q.bitn + 4'd1;
                    end else if (fall_w && q.bitn == 4'd8) begin
                        case (q.kind)
                            BK_DEV: begin
                                d.ack = (q.sh[7:1] == DEV_ADDR);
                                d.rd  = q.sh[0];
                            end
                            BK_PTR: begin
                                d.ack = (q.sh[7:6] == 2'b00) && probe_ok_i;
                                if (d.ack) begin
                                    d.ptr   = q.sh[PTR_W-1:0];
                                    d.first = 1'b1;
                                end
                            end
                            BK_HI: begin
                                d.ack  = 1'b1;
                                d.hold = q.sh;
                            end
                            default: begin
                                d.ack   = 1'b1;
                                cmt_en  = 1'b1;
                                d.ptr   = q.ptr + 6'd1;
                                d.first = 1'b0;
                            end
                        endcase
                        d.oe = d.ack;
                        d.st = LS_RX_ACK;
                    end
                end
                LS_RX_ACK: begin
                    if (fall_w) begin
                        d.oe   = 1'b0;
                        d.bitn = 4'd0;
                        if (!q.ack) begin
                            d.st = LS_WAIT;
                        end else begin
                            case (q.kind)
                                BK_DEV: begin
                                    if (q.rd) begin
                                        d.st   = LS_TX;
                                        d.half = 1'b0;
                                        d.sh   = rd_data_i[15:8];
                                        d.hold = rd_data_i[7:0];
                                        d.oe   = ~rd_data_i[15];
                                        d.bitn = 4'd1;
                                    end else begin
                                        d.st   = LS_RX;
                                        d.kind = BK_PTR;
                                    end
                                end
                                BK_PTR: begin
                                    d.st   = LS_RX;
                                    d.kind = BK_HI;
                                end
                                BK_HI: begin
                                    d.st   = LS_RX;
                                    d.kind = BK_LO;
                                end
                                default: begin
                                    d.st   = LS_RX;
                                    d.kind = BK_HI;
                                end
                            endcase
                        end
                    end
                end
                LS_TX: begin
                    if (fall_w) begin
                        if (q.bitn == 4'd8) begin
                            d.oe = 1'b0;
                            d.st = LS_TX_ACK;
                        end else begin
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.oe   = ~q.sh[6];
                            d.bitn = q.bitn + 4'd1;
                        end
                    end
                end
                LS_TX_ACK: begin
                    if (rise_w) begin
                        d.ack = ~sda_s;
                    end else if (fall_w) begin
                        if (!q.ack) begin
                            d.st = LS_WAIT;
                        end else begin
                            d.st   = LS_TX;
                            d.bitn = 4'd1;
                            if (!q.half) begin
                                d.sh   = q.hold;
                                d.half = 1'b1;
                                d.ptr  = q.ptr + 6'd1;
                                d.oe   = ~q.hold[7];
                            end else begin
                                d.sh   = rd_data_i[15:8];
                                d.hold = rd_data_i[7:0];
                                d.half = 1'b0;
                                d.oe   = ~rd_data_i[15];
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign probe_addr_o = q.sh[PTR_W-1:0];
    assign rd_addr_o    = q.ptr;
    assign cmt_en_o     = cmt_en;
    assign cmt_addr_o   = q.ptr;
    assign cmt_data_o   = {q.hold, q.sh};
    assign cmt_first_o  = q.first;
    assign sda_oe_o     = q.oe;

    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !scl_s); // R10
    AST_DEV_MISS_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == LS_RX && q.kind == BK_DEV && fall_w && q.bitn == 4'd8 &&
         q.sh[7:1] != DEV_ADDR && !start_w && !stop_w) |=> !q.oe); // R1
    AST_BAD_PTR_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == LS_RX && q.kind == BK_PTR && fall_w && q.bitn == 4'd8 &&
         q.sh[7:6] != 2'b00 && !start_w && !stop_w) |=> !q.oe); // R2
    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == LS_TX_ACK && fall_w && !q.ack && !start_w && !stop_w)
        |=> (!q.oe && q.st == LS_WAIT)); // R9
endmodule

// File: rtl/gt_regbank.sv
module gt_regbank
    import gt_pkg::*;
#(
    parameter int NUM_DAC = 8,
    parameter int LVL_W   = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PTR_W-1:0]         probe_addr_i,
    output logic                     probe_ok_o,
    input  logic [PTR_W-1:0]         rd_addr_i,
    output logic [WORD_W-1:0]        rd_data_o,
    input  logic                     cmt_en_i,
    input  logic [PTR_W-1:0]         cmt_addr_i,
    input  logic [WORD_W-1:0]        cmt_data_i,
    input  logic                     cmt_first_i,
    output logic [NUM_DAC*LVL_W-1:0] dac_o,
    output logic [LVL_W-1:0]         vcom_o,
    output logic [CTRL_N*WORD_W-1:0] ctrl_o
);
    localparam logic [PTR_W:0] DAC_END  = (PTR_W+1)'(NUM_DAC);
    localparam logic [PTR_W:0] CTRL_END = {1'b0, CTRL_BASE} + (PTR_W+1)'(CTRL_N);

    typedef struct packed {
        logic [NUM_DAC-1:0][LVL_W-1:0] dac;
        logic [LVL_W-1:0]              vcom;
        logic [CTRL_N-1:0][WORD_W-1:0] ctrl;
    } bank_s;

    bank_s d, q;

    function automatic logic is_known(input logic [PTR_W-1:0] a);
        is_known = ({1'b0, a} < DAC_END) || (a == VCOM_ADDR) ||
                   ((a >= CTRL_BASE) && ({1'b0, a} < CTRL_END));
    endfunction

    logic cmt_ok;

    always_comb begin
        d      = q;
        cmt_ok = cmt_en_i && (cmt_data_i[15:14] != RSVD_TAG);
        if (cmt_ok) begin
            for (int i = 0; i < NUM_DAC; i++) begin
                if (cmt_addr_i == PTR_W'(i)) d.dac[i] = cmt_data_i[LVL_W-1:0];
            end
            if (cmt_addr_i == VCOM_ADDR) d.vcom = cmt_data_i[LVL_W-1:0];
            if (cmt_first_i) begin
                for (int i = 0; i < CTRL_N; i++) begin
                    if (cmt_addr_i == CTRL_BASE + PTR_W'(i)) d.ctrl[i] = cmt_data_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_DAC; i++) begin
            if (rd_addr_i == PTR_W'(i)) rd_data_o = WORD_W'(q.dac[i]);
        end
        if (rd_addr_i == VCOM_ADDR) rd_data_o = WORD_W'(q.vcom);
        for (int i = 0; i < CTRL_N; i++) begin
            if (rd_addr_i == CTRL_BASE + PTR_W'(i)) rd_data_o = q.ctrl[i];
        end
    end

    assign probe_ok_o = is_known(probe_addr_i);
    assign dac_o      = q.dac;
    assign vcom_o     = q.vcom;
    assign ctrl_o     = q.ctrl;

    AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !cmt_en_i |=> $stable(q)); // R4
    AST_RSVD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_en_i && cmt_data_i[15:14] == RSVD_TAG) |=> $stable(q)); // R7
    AST_CTRL_BURST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_en_i && !cmt_first_i) |=> $stable(q.ctrl)); // R6
    AST_UNUSED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_en_i && !is_known(cmt_addr_i)) |=> $stable(q)); // R5
endmodule

// File: rtl/gamma_i2c_target.sv
module gamma_i2c_target
    import gt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2B,
    parameter int         NUM_DAC     = 8,
    parameter int         LVL_W       = 10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_oe_o,
    output logic [NUM_DAC*LVL_W-1:0] dac_lvl_o,
    output logic [LVL_W-1:0]         vcom_lvl_o,
    output logic [CTRL_N*WORD_W-1:0] ctrl_o
);
    logic [1:0]        line_s, line_p;
    logic [PTR_W-1:0]  probe_addr, rd_addr, cmt_addr;
    logic              probe_ok, cmt_en, cmt_first;
    logic [WORD_W-1:0] rd_data, cmt_data;

    gt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sda_i, scl_i}),
        .sync_o  (line_s),
        .prev_o  (line_p)
    );

    gt_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_s        (line_s[0]),
        .scl_p        (line_p[0]),
        .sda_s        (line_s[1]),
        .sda_p        (line_p[1]),
        .probe_addr_o (probe_addr),
        .probe_ok_i   (probe_ok),
        .rd_addr_o    (rd_addr),
        .rd_data_i    (rd_data),
        .cmt_en_o     (cmt_en),
        .cmt_addr_o   (cmt_addr),
        .cmt_data_o   (cmt_data),
        .cmt_first_o  (cmt_first),
        .sda_oe_o     (sda_oe_o)
    );

    gt_regbank #(.NUM_DAC(NUM_DAC), .LVL_W(LVL_W)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .probe_addr_i (probe_addr),
        .probe_ok_o   (probe_ok),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .cmt_en_i     (cmt_en),
        .cmt_addr_i   (cmt_addr),
        .cmt_data_i   (cmt_data),
        .cmt_first_i  (cmt_first),
        .dac_o        (dac_lvl_o),
        .vcom_o       (vcom_lvl_o),
        .ctrl_o       (ctrl_o)
    );
endmodule

// File: tb/sim_gamma_i2c_target.sv
module sim_gamma_i2c_target;
    localparam logic [6:0] DEV  = 7'h2B;
    localparam int         NDAC = 8;
    localparam int         LW   = 10;

    // {ptr_ack, ptr, write word, expected read word}
    localparam logic [40:0] VEC [8] = '{
        {1'b1, 8'h00, 16'h03FF, 16'h03FF},
        {1'b1, 8'h05, 16'hFD55, 16'h0155},
        {1'b1, 8'h12, 16'h0201, 16'h0201},
        {1'b1, 8'h3C, 16'hBEEF, 16'hBEEF},
        {1'b1, 8'h3F, 16'h0001, 16'h0001},
        {1'b1, 8'h07, 16'h4123, 16'h0000},
        {1'b0, 8'h08, 16'h0099, 16'h0000},
        {1'b0, 8'h47, 16'h0099, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_oe;
    logic sda_bus;
    logic [NDAC*LW-1:0] dac;
    logic [LW-1:0]      vcom;
    logic [63:0]        ctrl;

    assign sda_bus = sda_drv & ~sda_oe;

    gamma_i2c_target #(.DEV_ADDR(DEV), .NUM_DAC(NDAC), .LVL_W(LW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_drv),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .dac_lvl_o  (dac),
        .vcom_lvl_o (vcom),
        .ctrl_o     (ctrl)
    );

    int errors = 0;
    int checks = 0;
    logic [15:0] wbuf [0:19];
    logic [15:0] rbuf [0:3];

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wq();
        repeat (8) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq();
        sda_drv = 1'b0; wq(); scl_drv = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wq(); scl_drv = 1'b1; wq(); sda_drv = 1'b1; wq();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wq(); scl_drv = 1'b1; wq(); wq(); scl_drv = 1'b0; wq();
        end
        sda_drv = 1'b1; wq(); scl_drv = 1'b1; wq(); ack = ~sda_bus; wq();
        scl_drv = 1'b0; wq();
    endtask

    task automatic get_byte(input logic ack, output logic [7:0] b);
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_drv = 1'b1; wq(); b[i] = sda_bus; wq(); scl_drv = 1'b0; wq();
        end
        sda_drv = ~ack; wq(); scl_drv = 1'b1; wq(); wq(); scl_drv = 1'b0; wq();
        sda_drv = 1'b1;
    endtask

    task automatic wr_burst(input logic [7:0] ptr, input int n,
                            output logic all_ack, output logic ptr_ack);
        logic a;
        bus_start();
        put_byte({DEV, 1'b0}, a);
        all_ack = a;
        put_byte(ptr, ptr_ack);
        all_ack &= ptr_ack;
        if (ptr_ack) begin
            for (int k = 0; k < n; k++) begin
                put_byte(wbuf[k][15:8], a); all_ack &= a;
                put_byte(wbuf[k][7:0], a);  all_ack &= a;
            end
        end
        bus_stop();
    endtask

    task automatic rd_burst(input logic [7:0] ptr, input int n);
        logic a;
        logic [7:0] hi, lo;
        bus_start();
        put_byte({DEV, 1'b0}, a);
        put_byte(ptr, a);
        bus_start();
        put_byte({DEV, 1'b1}, a);
        for (int k = 0; k < n; k++) begin
            get_byte(1'b1, hi);
            get_byte(k != n - 1, lo);
            rbuf[k] = {hi, lo};
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic aa, pa, a;
        logic [7:0] hi, lo, extra;
        logic [NDAC*LW-1:0] dac_snap;
        logic [LW-1:0] vcom_snap;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10: reset state
        chk(sda_oe == 1'b0, "R10", 32'(sda_oe), 32'd0, "sda enable after reset");
        chk(dac == '0 && vcom == '0, "R10", 32'(dac[31:0]), 32'd0, "levels after reset");
        chk(ctrl == '0, "R10", ctrl[31:0], 32'd0, "control after reset");

        // Table: single-word write then read back
        for (int v = 0; v < 8; v++) begin
            dac_snap  = dac;
            vcom_snap = vcom;
            wbuf[0] = VEC[v][31:16];
            wr_burst(VEC[v][39:32], 1, aa, pa);
            chk(pa == VEC[v][40], "R2", 32'(pa), 32'(VEC[v][40]), "pointer ack");
            if (VEC[v][40]) begin
                if (v == 0) chk(aa == 1'b1, "R1", 32'(aa), 32'd1, "matching address acked");
                rd_burst(VEC[v][39:32], 1);
                chk(rbuf[0] == VEC[v][15:0], (v == 5) ? "R7" : "R3",
                    32'(rbuf[0]), 32'(VEC[v][15:0]), "readback");
            end else begin
                chk(dac == dac_snap && vcom == vcom_snap, "R2",
                    32'(dac[31:0]), 32'(dac_snap[31:0]), "bad pointer left registers");
            end
        end

        // R1: wrong device address
        bus_start();
        put_byte({7'h2A, 1'b0}, a);
        chk(a == 1'b0, "R1", 32'(a), 32'd0, "foreign address nacked");
        put_byte(8'h00, a);
        put_byte(8'h00, a);
        put_byte(8'h00, a);
        bus_stop();
        chk(dac[0 +: LW] == 10'h3FF, "R1", 32'(dac[0 +: LW]), 32'h3FF, "foreign write ignored");

        // R4: upper byte only, ended by STOP
        bus_start();
        put_byte({DEV, 1'b0}, a);
        put_byte(8'h02, a);
        put_byte(8'h01, a);
        bus_stop();
        chk(dac[2*LW +: LW] == '0, "R4", 32'(dac[2*LW +: LW]), 32'd0, "half word then stop");

        // R4: upper byte only, ended by repeated START
        bus_start();
        put_byte({DEV, 1'b0}, a);
        put_byte(8'h03, a);
        put_byte(8'h01, a);
        bus_start();
        put_byte({DEV, 1'b0}, a);
        put_byte(8'h04, a);
        put_byte(8'h00, a);
        put_byte(8'h77, a);
        bus_stop();
        chk(dac[3*LW +: LW] == '0, "R4", 32'(dac[3*LW +: LW]), 32'd0, "half word then restart");
        chk(dac[4*LW +: LW] == 10'h077, "R4", 32'(dac[4*LW +: LW]), 32'h077, "full word commits");

        // R5: 19-word burst reaching the common-voltage register
        for (int i = 0; i < 18; i++) wbuf[i] = 16'h0040 + 16'(i);
        wbuf[18] = 16'h02AA;
        wr_burst(8'h00, 19, aa, pa);
        chk(aa == 1'b1, "R5", 32'(aa), 32'd1, "all burst bytes acked");
        for (int i = 0; i < NDAC; i++)
            chk(dac[i*LW +: LW] == LW'(16'h0040 + 16'(i)), "R5",
                32'(dac[i*LW +: LW]), 32'h40 + 32'(i), "burst level slot");
        chk(vcom == 10'h2AA, "R5", 32'(vcom), 32'h2AA, "19th word in common voltage");

        // R7: reserved tag inside a burst
        wbuf[0] = 16'h0011; wbuf[1] = 16'h4022; wbuf[2] = 16'h0033;
        wr_burst(8'h00, 3, aa, pa);
        chk(aa == 1'b1, "R7", 32'(aa), 32'd1, "reserved word acked");
        chk(dac[1*LW +: LW] == 10'h041, "R7", 32'(dac[1*LW +: LW]), 32'h041, "reserved word dropped");
        chk(dac[2*LW +: LW] == 10'h033, "R7", 32'(dac[2*LW +: LW]), 32'h033, "pointer moved past it");

        // R6: control registers only by the first word
        wbuf[0] = 16'h1234; wbuf[1] = 16'h5678;
        wr_burst(8'h3E, 2, aa, pa);
        chk(aa == 1'b1, "R6", 32'(aa), 32'd1, "control burst acked");
        chk(ctrl[2*16 +: 16] == 16'h1234, "R6", 32'(ctrl[2*16 +: 16]), 32'h1234, "first word written");
        chk(ctrl[3*16 +: 16] == 16'h0001, "R6", 32'(ctrl[3*16 +: 16]), 32'h0001, "continuation dropped");

        // R8, R9: read burst crossing into an unused slot
        rd_burst(8'h06, 3);
        chk(rbuf[0] == 16'h0046, "R9", 32'(rbuf[0]), 32'h0046, "read word 0");
        chk(rbuf[1] == 16'h0047, "R9", 32'(rbuf[1]), 32'h0047, "read word 1");
        chk(rbuf[2] == 16'h0000, "R8", 32'(rbuf[2]), 32'h0000, "unused slot reads zero");

        // R9: not-acknowledge ends the read
        bus_start();
        put_byte({DEV, 1'b0}, a);
        put_byte(8'h05, a);
        bus_start();
        put_byte({DEV, 1'b1}, a);
        get_byte(1'b1, hi);
        get_byte(1'b0, lo);
        chk({hi, lo} == 16'h0045, "R8", 32'({hi, lo}), 32'h0045, "selected word returned");
        chk(sda_oe == 1'b0, "R9", 32'(sda_oe), 32'd0, "released after nack");
        get_byte(1'b0, extra);
        chk(extra == 8'hFF, "R9", 32'(extra), 32'hFF, "no data after nack");
        bus_stop();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule